// File: doc/BRIEF.md
# Byte-Paced I2C Master Controller

This block is an I2C bus master that software steers one byte at a time through four small registers: control, status, data and own-address. Software loads the data register and writes the status register to launch a START, a repeated START or a STOP. The engine then shifts one byte onto the bus or off it, together with its ninth acknowledge bit. At the end of every byte the engine raises a pending flag and holds SCL low. The bus stays frozen until software clears the flag, which starts the next byte phase or the queued bus condition.

The bit clock is derived from the system clock. A control bit selects one of two prescaler values, and a 4-bit divisor divides further. SCL and SDA are open-drain: the block only ever pulls a line low or releases it. Both lines are read back through a two-flop synchronizer. A target that holds SCL low therefore stretches the current bit, and the engine waits until the line is seen high. Slave operation, arbitration between masters and 10-bit addressing are not part of this block.

Host access is a plain register port. A write takes effect on the clock edge where `reg_wr` is high. A read returns the register selected by `reg_addr` combinationally. Register offsets are 0 control, 1 status, 2 data and 3 own-address.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, control reads 0x00, status reads 0x00 (slave-receive, idle), data reads 0x00, and own-address reads the OWN_ADDR_RST parameter (default 0x24). Both pins are released and `irq` is low. Own-address is writable and reads back.
- R2: One SCL period lasts P × (D + 1) system clocks. D is control bits [3:0]. P is 16 when control bit 6 is 0 and 512 when it is 1.
- R3: When the bus is idle, writing status with bits [7:6] = 1x (a master mode), bit 5 = 1 and bit 4 = 1 produces a START, with SDA falling while SCL is high. The data register is then sent MSB first as the address byte. Status bit 5 reads 1 from that write until the STOP completes.
- R4: When any byte completes, its ninth bit included, control bit 4 (pending) sets and SCL stays low. Writing control with bit 4 = 0 clears pending and releases the next step. Writing bit 4 = 1 neither sets nor clears it.
- R5: `irq` equals pending while control bit 5 is 1, and is 0 while control bit 5 is 0.
- R6: Status bit 0 holds the ninth bit sampled on the bus for the last byte: 1 for NACK, 0 for ACK.
- R7: In master-transmit mode (status bits [7:6] = 11), clearing pending sends the data register MSB first and samples the target's acknowledge.
- R8: In master-receive mode (status bits [7:6] = 10), clearing pending clocks in one byte MSB first, and the byte is in the data register when pending rises. The master pulls the ninth bit low (ACK) when control bit 7 is 1 and releases it (NACK) when control bit 7 is 0.
- R9: Writing status with bit 5 = 1 while the bus is held, then clearing pending, produces a repeated START followed by the data register as the address byte.
- R10: Writing status with bit 5 = 0 while the bus is held, then clearing pending, produces a STOP (SDA rising while SCL is high). Status bit 5 then returns to 0 with both pins released. The same write while idle has no effect.
- R11: During a byte, the block changes its SDA drive only while it is driving SCL low.
- R12: A target holding SCL low lengthens the current bit, and the byte still completes correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 control, 1 status, 2 data, 3 own-address) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| irq | output | 1 | Interrupt: pending gated by enable |
| scl_i | input | 1 | SCL line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The main write transaction runs once for each of four clock settings: the short prescaler with divisors 0, 3 and 15, and the long prescaler with divisor 0. The measured SCL period separates the prescaler choice from the divisor arithmetic, and the data byte is checked at a bus-model target. A register-read sequence with a repeated START and two received bytes tells ACK generation apart from the final NACK. An unmatched address tells a sampled NACK apart from an ACK. A one-shot clock stretch, held pending and idle STOP writes show that the engine waits rather than runs ahead.

// File: rtl/i2c_bm_pkg.sv
package i2c_bm_pkg;

    localparam int DATA_W = 8;
    localparam int DIV_W  = 4;

    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_STAT = 2'd1;
    localparam logic [1:0] REG_DATA = 2'd2;
    localparam logic [1:0] REG_OWN  = 2'd3;

    typedef enum logic [1:0] {
        MODE_SRX = 2'b00,
        MODE_STX = 2'b01,
        MODE_MRX = 2'b10,
        MODE_MTX = 2'b11
    } bm_mode_e;

    typedef enum logic [1:0] {
        CMD_START,
        CMD_NEXT,
        CMD_RESTART,
        CMD_STOP
    } bm_cmd_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START1,
        ST_START2,
        ST_BIT,
        ST_HOLD,
        ST_RS1,
        ST_RS2,
        ST_STOP1,
        ST_STOP2,
        ST_STOP3,
        ST_STOP4
    } bm_state_e;

endpackage

// File: rtl/i2c_bm_sync.sv
module i2c_bm_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    // stage 0 takes the raw line, each later stage the one before
    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_comb pipe_d[s] = d_i;
            end else begin : g_next
                always_comb pipe_d[s] = pipe_q[s-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;   // idle bus reads high
        else        pipe_q <= pipe_d;
    end

    assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/i2c_bm_tick.sv
module i2c_bm_tick #(
    parameter int PRE_LO = 16,
    parameter int PRE_HI = 512,
    parameter int DIV_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             presc_hi,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    // four quarter ticks make one SCL period
    localparam int Q_LO    = PRE_LO / 4;
    localparam int Q_HI    = PRE_HI / 4;
    localparam int CNT_MAX = Q_HI * (1 << DIV_W);
    localparam int CW      = $clog2(CNT_MAX);

    logic [CW:0] unit, limit;
    logic [CW:0] cnt_d, cnt_q;

    always_comb begin
        unit  = presc_hi ? (CW+1)'(Q_HI) : (CW+1)'(Q_LO);
        limit = unit * ((CW+1)'(div) + (CW+1)'(1)) - (CW+1)'(1);
        tick  = (cnt_q >= limit);
        cnt_d = tick ? '0 : cnt_q + (CW+1)'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/i2c_bm_engine.sv
module i2c_bm_engine
    import i2c_bm_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              cmd_valid,
    input  bm_cmd_e           cmd,
    input  logic [BYTE_W-1:0] cmd_byte,
    input  logic              cmd_rx,
    input  logic              ack_en,
    output logic              scl_low,
    output logic              sda_low,
    output logic              busy,
    output logic              holding,
    output logic              in_byte,
    output logic              done,
    output logic              done_rx,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              ack_bit
);
    localparam int BW = $clog2(BYTE_W + 1);
    localparam logic [BW-1:0] LAST = BW'(BYTE_W);

    typedef struct packed {
        bm_state_e         st;
        logic [1:0]        q;
        logic [BW-1:0]     bitn;
        logic [BYTE_W-1:0] sh;
        logic              rx;
        logic              scl_low;
        logic              sda_low;
    } eng_t;

    eng_t eng_d, eng_q;

    always_comb begin
        eng_d = eng_q;
        unique case (eng_q.st)
            ST_IDLE: begin
                eng_d.scl_low = 1'b0;
                eng_d.sda_low = 1'b0;
                if (cmd_valid && cmd == CMD_START) begin
                    eng_d.st = ST_START1;
                    eng_d.sh = cmd_byte;
                end
            end
            ST_START1: if (tick && scl_s) begin
                eng_d.sda_low = 1'b1;
                eng_d.st      = ST_START2;
            end
            ST_START2: if (tick) begin
                eng_d.scl_low = 1'b1;
                eng_d.st      = ST_BIT;
                eng_d.q       = 2'd0;
                eng_d.bitn    = '0;
                eng_d.rx      = 1'b0;
            end
            ST_BIT: if (tick) begin
                unique case (eng_q.q)
                    2'd0: begin
                        // SCL is low here: set up the next bit
                        if (eng_q.bitn == LAST)
                            eng_d.sda_low = eng_q.rx & ack_en;
                        else
                            eng_d.sda_low = ~eng_q.rx & ~eng_q.sh[BYTE_W-1];
                        eng_d.q = 2'd1;
                    end
                    2'd1: begin
                        eng_d.scl_low = 1'b0;
                        eng_d.q       = 2'd2;
                    end
                    2'd2: if (scl_s) eng_d.q = 2'd3;   // waits out a stretch
                    default: begin
                        eng_d.scl_low = 1'b1;
                        eng_d.q       = 2'd0;
                        if (eng_q.bitn == LAST) begin
                            eng_d.st = ST_HOLD;
                        end else begin
                            eng_d.sh   = {eng_q.sh[BYTE_W-2:0], sda_s};
                            eng_d.bitn = eng_q.bitn + BW'(1);
                        end
                    end
                endcase
            end
            ST_HOLD: begin
                if (cmd_valid) begin
                    unique case (cmd)
                        CMD_NEXT: begin
                            eng_d.st   = ST_BIT;
                            eng_d.q    = 2'd0;
                            eng_d.bitn = '0;
                            eng_d.sh   = cmd_byte;
                            eng_d.rx   = cmd_rx;
                        end
                        CMD_RESTART: begin
                            eng_d.st = ST_RS1;
                            eng_d.sh = cmd_byte;
                        end
                        CMD_STOP: eng_d.st = ST_STOP1;
                        default: ;
                    endcase
                end else if (tick) begin
                    eng_d.sda_low = 1'b0;   // let go of a driven ACK
                end
            end
            ST_RS1: if (tick) begin
                eng_d.sda_low = 1'b0;
                eng_d.st      = ST_RS2;
            end
            ST_RS2: if (tick) begin
                eng_d.scl_low = 1'b0;
                eng_d.st      = ST_START1;
            end
            ST_STOP1: if (tick) begin
                eng_d.sda_low = 1'b1;
                eng_d.st      = ST_STOP2;
            end
            ST_STOP2: if (tick) begin
                eng_d.scl_low = 1'b0;
                eng_d.st      = ST_STOP3;
            end
            ST_STOP3: if (tick && scl_s) begin
                eng_d.sda_low = 1'b0;
                eng_d.st      = ST_STOP4;
            end
            ST_STOP4: if (tick) eng_d.st = ST_IDLE;
            default: eng_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '{st: ST_IDLE, q: 2'd0, bitn: '0, sh: '0,
                               rx: 1'b0, scl_low: 1'b0, sda_low: 1'b0};
        else        eng_q <= eng_d;
    end

    assign scl_low = eng_q.scl_low;
    assign sda_low = eng_q.sda_low;
    assign busy    = (eng_q.st != ST_IDLE);
    assign holding = (eng_q.st == ST_HOLD);
    assign in_byte = (eng_q.st == ST_BIT);
    assign done    = tick && in_byte && (eng_q.q == 2'd3) && (eng_q.bitn == LAST);
    assign done_rx = eng_q.rx;
    assign rx_byte = eng_q.sh;
    assign ack_bit = sda_s;
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
    import i2c_bm_pkg::*;
#(
    parameter int          PRE_LO       = 16,
    parameter int          PRE_HI       = 512,
    parameter logic [7:0]  OWN_ADDR_RST = 8'h24
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq,
    input  logic       scl_i,
    output logic       scl_oe,
    input  logic       sda_i,
    output logic       sda_oe
);
    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic              pend;
        logic              int_en;
        logic              presc_hi;
        logic              ack_en;
        bm_mode_e          mode;
        logic              oe;
        logic [DATA_W-1:0] data;
        logic [DATA_W-1:0] own;
        logic              nack;
        logic              rs_req;
        logic              stop_req;
    } regs_t;

    regs_t regs_d, regs_q;

    logic              tick;
    logic [1:0]        pins_s;
    logic              cmd_valid;
    bm_cmd_e           cmd;
    logic [DATA_W-1:0] cmd_byte;
    logic              cmd_rx;
    logic              eng_busy, eng_hold, eng_in_byte, eng_done, eng_done_rx, eng_ack;
    logic [DATA_W-1:0] eng_rx_byte;
    logic              st_pend;

    i2c_bm_sync #(.W(2), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i({scl_i, sda_i}), .q_o(pins_s)
    );

    i2c_bm_tick #(.PRE_LO(PRE_LO), .PRE_HI(PRE_HI), .DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .presc_hi(regs_q.presc_hi),
        .div(regs_q.div), .tick(tick)
    );

    i2c_bm_engine #(.BYTE_W(DATA_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .scl_s(pins_s[1]), .sda_s(pins_s[0]),
        .cmd_valid(cmd_valid), .cmd(cmd), .cmd_byte(cmd_byte), .cmd_rx(cmd_rx),
        .ack_en(regs_q.ack_en),
        .scl_low(scl_oe), .sda_low(sda_oe),
        .busy(eng_busy), .holding(eng_hold), .in_byte(eng_in_byte),
        .done(eng_done), .done_rx(eng_done_rx), .rx_byte(eng_rx_byte),
        .ack_bit(eng_ack)
    );

    always_comb begin
        regs_d    = regs_q;
        cmd_valid = 1'b0;
        cmd       = CMD_NEXT;
        cmd_byte  = regs_q.data;
        cmd_rx    = 1'b0;
        if (reg_wr) begin
            unique case (reg_addr)
                REG_CTRL: begin
                    regs_d.div      = reg_wdata[3:0];
                    regs_d.int_en   = reg_wdata[5];
                    regs_d.presc_hi = reg_wdata[6];
                    regs_d.ack_en   = reg_wdata[7];
                    if (!reg_wdata[4]) begin
                        regs_d.pend = 1'b0;
                        if (regs_q.pend && eng_hold) begin
                            cmd_valid = 1'b1;
                            if (regs_q.stop_req) begin
                                cmd             = CMD_STOP;
                                regs_d.stop_req = 1'b0;
                                regs_d.rs_req   = 1'b0;
                            end else if (regs_q.rs_req) begin
                                cmd           = CMD_RESTART;
                                regs_d.rs_req = 1'b0;
                            end else begin
                                cmd    = CMD_NEXT;
                                cmd_rx = (regs_q.mode == MODE_MRX);
                            end
                        end
                    end
                end
                REG_STAT: begin
                    regs_d.mode = bm_mode_e'(reg_wdata[7:6]);
                    regs_d.oe   = reg_wdata[4];
                    if (reg_wdata[5] && reg_wdata[7] && reg_wdata[4]) begin
                        if (!eng_busy) begin
                            cmd_valid = 1'b1;
                            cmd       = CMD_START;
                        end else begin
                            regs_d.rs_req   = 1'b1;
                            regs_d.stop_req = 1'b0;
                        end
                    end else if (!reg_wdata[5] && eng_busy) begin
                        regs_d.stop_req = 1'b1;
                        regs_d.rs_req   = 1'b0;
                    end
                end
                REG_DATA: regs_d.data = reg_wdata;
                default:  regs_d.own  = reg_wdata;
            endcase
        end
        if (eng_done) begin
            regs_d.pend = 1'b1;
            regs_d.nack = eng_ack;
            if (eng_done_rx) regs_d.data = eng_rx_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '{div: '0, pend: 1'b0, int_en: 1'b0, presc_hi: 1'b0,
                                ack_en: 1'b0, mode: MODE_SRX, oe: 1'b0, data: '0,
                                own: OWN_ADDR_RST, nack: 1'b0, rs_req: 1'b0,
                                stop_req: 1'b0};
        else        regs_q <= regs_d;
    end

    always_comb begin
        unique case (reg_addr)
            REG_CTRL: reg_rdata = {regs_q.ack_en, regs_q.presc_hi, regs_q.int_en,
                                   regs_q.pend, regs_q.div};
            REG_STAT: reg_rdata = {regs_q.mode, eng_busy, regs_q.oe, 3'b000, regs_q.nack};
            REG_DATA: reg_rdata = regs_q.data;
            default:  reg_rdata = regs_q.own;
        endcase
    end

    assign irq     = regs_q.pend & regs_q.int_en;
    assign st_pend = regs_q.pend;
endmodule

// File: rtl/i2c_byte_master_chk.sv
module i2c_byte_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pend,
    input logic       busy,
    input logic       in_byte,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic       reg_wr,
    input logic [1:0] reg_addr,
    input logic [7:0] reg_wdata
);
    // R11: SDA drive is frozen while SCL is released inside a byte
    p_sda_still_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_byte && !scl_oe) |=> $stable(sda_oe));

    // R4: a pending byte on a held bus keeps SCL pulled low
    p_scl_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && busy) |-> scl_oe);

    // R4: pending only drops after a control write with bit 4 clear
    p_pend_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend) |-> $past(reg_wr && (reg_addr == 2'd0) && !reg_wdata[4]));

    // R10: leaving the bus leaves both pins released
    p_free_after_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (!scl_oe && !sda_oe));

    // R3: a transaction begins with both lines released, ahead of the START edge
    p_start_from_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (!scl_oe && !sda_oe));
endmodule

bind i2c_byte_master i2c_byte_master_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pend(st_pend), .busy(eng_busy),
    .in_byte(eng_in_byte), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/i2c_byte_master_tb.sv
module i2c_byte_master_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq, scl_oe, sda_oe;
    logic       s_sda_low = 1'b0, s_scl_hold = 1'b0;
    logic       scl_line, sda_line;

    always #2 clk = ~clk;   // 250 MHz

    assign scl_line = ~(scl_oe | s_scl_hold);
    assign sda_line = ~(sda_oe | s_sda_low);

    i2c_byte_master u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .scl_i(scl_line), .scl_oe(scl_oe), .sda_i(sda_line), .sda_oe(sda_oe)
    );

    int n_checks = 0, n_fail = 0, cyc = 0;
    bit finished = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // ---------------- bus-model target ----------------
    localparam logic [6:0] SLV = 7'h52;
    int         s_bc = 0, s_starts = 0, s_stops = 0, s_rx_n = 0, s_stretch = 0;
    bit         s_in_addr = 0, s_rd = 0, s_match = 0, s_tx = 0, s_mack = 0;
    logic [7:0] s_sh = 0, s_txb = 0, s_next_tx = 8'hC3;
    logic [7:0] s_rx [0:7];
    int         t_prev = 0, t_last = 0;

    always @(negedge sda_line) if (rst_n && scl_line === 1'b1) begin
        s_starts++; s_bc = 0; s_in_addr = 1; s_tx = 0; s_sda_low = 0;
    end
    always @(posedge sda_line) if (rst_n && scl_line === 1'b1) begin
        s_stops++; s_in_addr = 0; s_tx = 0;
    end
    always @(posedge scl_line) if (rst_n) begin
        t_prev = t_last; t_last = cyc;
        if (s_bc < 8) begin
            if (!s_tx) s_sh = {s_sh[6:0], sda_line};
        end else if (s_bc == 8) s_mack = ~sda_line;
        s_bc++;
    end
    always @(negedge scl_line) if (rst_n) begin
        if (s_bc == 8) begin
            if (!s_tx) begin
                if (s_in_addr) begin
                    s_match = (s_sh[7:1] == SLV); s_rd = s_sh[0]; s_sda_low = s_match;
                end else if (s_match) begin
                    if (s_rx_n < 8) s_rx[s_rx_n] = s_sh;
                    s_rx_n++; s_sda_low = 1;
                end
            end else s_sda_low = 0;
        end else if (s_bc == 9) begin
            s_sda_low = 0; s_bc = 0;
            if (s_in_addr) begin s_in_addr = 0; s_tx = s_match && s_rd; end
            else if (s_tx && !s_mack) s_tx = 0;
            if (s_tx) begin
                s_txb = s_next_tx; s_next_tx = s_next_tx + 8'h11; s_sda_low = ~s_txb[7];
            end
        end else if (s_bc >= 1 && s_bc <= 7 && s_tx) s_sda_low = ~s_txb[7 - s_bc];
    end
    always @(negedge scl_line) if (rst_n && s_stretch > 0) begin
        s_scl_hold = 1;
        repeat (s_stretch) @(posedge clk);
        s_scl_hold = 0; s_stretch = 0;
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask
    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask
    task automatic wait_pend(output int t);
        logic [7:0] v;
        for (int k = 0; k < 20000; k++) begin rd(2'd0, v); if (v[4]) break; end
        t = cyc;
    endtask
    task automatic wait_idle();
        logic [7:0] v;
        for (int k = 0; k < 20000; k++) begin rd(2'd1, v); if (!v[5]) break; end
    endtask

    typedef struct packed { logic [7:0] ctrl; logic [7:0] data; logic [15:0] period; } vec_t;
    localparam vec_t VECS [4] = '{
        '{8'hA0, 8'h3C, 16'd16},
        '{8'hA3, 8'hC5, 16'd64},
        '{8'hAF, 8'h7E, 16'd256},
        '{8'hE0, 8'h81, 16'd512}
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int t0, t1, st0, sp0, lows;
        repeat (5) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd(2'd0, v); chk("R1 ctrl", v, 8'h00);
        rd(2'd1, v); chk("R1 status", v, 8'h00);
        rd(2'd2, v); chk("R1 data", v, 8'h00);
        rd(2'd3, v); chk("R1 own", v, 8'h24);
        chk("R1 pins", {scl_oe, sda_oe, irq}, 3'b000);
        wr(2'd3, 8'h7E); rd(2'd3, v); chk("R1 own rw", v, 8'h7E);

        // table: one write transaction per clock setting (R2 R3 R5 R6 R7 R10)
        foreach (VECS[i]) begin
            s_rx_n = 0; sp0 = s_stops; s_match = 0;
            wr(2'd0, VECS[i].ctrl);
            wr(2'd2, {SLV, 1'b0});
            wr(2'd1, 8'hF0);
            rd(2'd1, v); chk("R3 busy after start", v[5], 1'b1);
            wait_pend(t0);
            chk("R3 address matched", s_match, 1'b1);
            rd(2'd1, v); chk("R6 address ack", v[0], 1'b0);
            chk("R5 irq with enable", irq, 1'b1);
            wr(2'd2, VECS[i].data);
            t0 = cyc;
            wr(2'd0, VECS[i].ctrl);
            wait_pend(t1);
            chk("R7 byte at target", (s_rx_n == 1) ? s_rx[0] : 8'hxx, VECS[i].data);
            chk("R2 scl period", t_last - t_prev, VECS[i].period);
            if (VECS[i].period == 16) chk("R12 nominal byte time", (t1 - t0) <= 170, 1'b1);
            wr(2'd1, 8'hD0);
            wr(2'd0, VECS[i].ctrl);
            wait_idle();
            chk("R10 stop seen", s_stops - sp0, 1);
            chk("R10 lines free", {scl_oe, sda_oe}, 2'b00);
        end

        // R9 R8: register address write, repeated start, two-byte read
        st0 = s_starts; sp0 = s_stops; s_rx_n = 0; s_next_tx = 8'hC3;
        wr(2'd0, 8'hA0);
        wr(2'd2, {SLV, 1'b0}); wr(2'd1, 8'hF0); wait_pend(t0);
        wr(2'd2, 8'h10); wr(2'd0, 8'hA0); wait_pend(t0);
        chk("R7 register byte", s_rx[0], 8'h10);
        wr(2'd2, {SLV, 1'b1}); wr(2'd1, 8'hB0); wr(2'd0, 8'hA0); wait_pend(t0);
        chk("R9 repeated start", s_starts - st0, 2);
        rd(2'd1, v); chk("R9 read address ack", v[0], 1'b0);
        wr(2'd0, 8'hA0); wait_pend(t0);
        rd(2'd2, v); chk("R8 first rx byte", v, 8'hC3);
        chk("R8 master ack", s_mack, 1'b1);
        rd(2'd1, v); chk("R6 ack on rx", v[0], 1'b0);
        wr(2'd0, 8'h20); wait_pend(t0);
        rd(2'd2, v); chk("R8 last rx byte", v, 8'hD4);
        chk("R8 master nack", s_mack, 1'b0);
        rd(2'd1, v); chk("R6 nack on last rx", v[0], 1'b1);
        wr(2'd1, 8'h90); wr(2'd0, 8'h20); wait_idle();
        chk("R10 stop after read", s_stops - sp0, 1);

        // R6 R4 R5: unmatched address, held pending
        wr(2'd0, 8'hA0);
        wr(2'd2, 8'hB0); wr(2'd1, 8'hF0); wait_pend(t0);
        rd(2'd1, v); chk("R6 nack unmatched", v[0], 1'b1);
        lows = 0;
        for (int k = 0; k < 300; k++) begin @(negedge clk); if (scl_line !== 1'b0) lows++; end
        chk("R4 scl held while pending", lows, 0);
        wr(2'd0, 8'hB0);
        rd(2'd0, v); chk("R4 write one keeps pending", v[4], 1'b1);
        repeat (50) @(negedge clk);
        chk("R4 still held", scl_line, 1'b0);
        wr(2'd0, 8'h90);
        rd(2'd0, v); chk("R5 pending set", v[4], 1'b1);
        chk("R5 irq masked", irq, 1'b0);
        wr(2'd1, 8'hD0); wr(2'd0, 8'hA0); wait_idle();

        // R4 R10: idle writes have no effect
        wr(2'd0, 8'hB0); rd(2'd0, v); chk("R4 write one does not set", v, 8'hA0);
        st0 = s_starts; sp0 = s_stops;
        wr(2'd1, 8'hD0);
        repeat (50) @(negedge clk);
        rd(2'd1, v); chk("R10 idle stop no busy", v[5], 1'b0);
        chk("R10 idle stop no bus activity", {s_starts - st0, s_stops - sp0}, 64'd0);
        chk("R10 idle lines", {scl_oe, sda_oe}, 2'b00);

        // R12: target stretches the first bit of a data byte
        s_rx_n = 0; sp0 = s_stops;
        wr(2'd0, 8'hA0);
        wr(2'd2, {SLV, 1'b0}); wr(2'd1, 8'hF0); wait_pend(t0);
        s_stretch = 200;
        wr(2'd2, 8'h5A); t0 = cyc; wr(2'd0, 8'hA0); wait_pend(t1);
        chk("R12 stretched byte time", (t1 - t0) >= 328, 1'b1);
        chk("R12 stretched byte data", s_rx[0], 8'h5A);
        wr(2'd1, 8'hD0); wr(2'd0, 8'hA0); wait_idle();
        chk("R12 stop after stretch", s_stops - sp0, 1);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule